// File: doc/BRIEF.md
# Calendar Counter with Alarm

This block keeps calendar time in seven binary fields: year, month, day of month, day of week, hour, minute and second. A pulse on the one-second tick input advances the seconds field by one. Carries pass from the seconds field up through the larger fields, and all fields update on the same clock edge. The month length depends on the month and on whether the year is a leap year. The year field counts from 0 to 99 and then wraps to 0. Year 0 is treated as a common year.

Software uses a simple 32-bit register bus. Before loading a new time, it sets a stop bit, which freezes counting. Clearing the stop bit lets the counter run again. A second set of seven fields holds an alarm time. An alarm control byte holds a master enable and one compare enable for each field. When an advancing tick produces a time that matches every enabled alarm field, a sticky status bit is set. The interrupt line is high while that status bit is set and the alarm is enabled. Software clears the status by writing a one to it.

Top module: `cal_clock`

## Requirements
- R1: After reset the fields read year 0, month 1, day of month 1, and 0 for day of week, hour, minute and second. The stop bit reads 1, the alarm control reads 0, the status reads 0 and `irq` is low.
- R2: Time field i sits at byte offset 0x40 + 4*i, and alarm field i sits at 0x60 + 4*i. The field order is i = 0 year, 1 month, 2 day of month, 3 day of week, 4 hour, 5 minute, 6 second. A read returns the field zero-extended. A write stores the low bits of the write data.
- R3: When the stop bit is clear, a tick adds one to the second. Second 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and carries into the day fields.
- R4: Bit 0 of the control register at offset 0x20 is the stop bit. While it is 1, ticks leave all fields unchanged. After it is written to 0, ticks advance the time again.
- R5: The day of month wraps to 1 after the last day of its month and carries into the month. Month lengths are 31 or 30 days, and February has 28 or 29. Month 12 wraps to 1 and carries into the year.
- R6: Year 99 wraps to 0. A year value is a leap year only when it is nonzero and divisible by 4, so February of year 0 has 28 days.
- R7: The day of week increments on every day carry and wraps from 6 to 0.
- R8: The alarm control register is at offset 0x7C. Bit 0 is the master enable, and bit i+1 enables the compare for field i. When an advancing tick produces a time equal to the alarm in every enabled field, and the master enable is set, the status bit (bit 4 at offset 0x30) becomes 1.
- R9: `irq` is high while the status bit is 1 and the master enable is 1. Writing 0 to the alarm control drops `irq`.
- R10: Writing 1 to bit 4 at offset 0x30 clears the status. Writing 0 to that bit has no effect.
- R11: An alarm hit in the same cycle as a status-clear write leaves the status set. A time-field write in the same cycle as a tick takes effect, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| irq | output | 1 | Alarm interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an alarm hit and a write that clears the status. The second pair is a tick and a software write to a time field. The bench provokes each collision by issuing the bus write with the tick held high in the same cycle. For the first pair, the status must read 1 afterward. For the second pair, the seconds field must hold the written value with no increment added.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFIELD  = 7;
  localparam int FIELD_W = 7;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTL  = 8'h20;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] A_ACTL = 8'h7C;
  localparam int STAT_BIT = 4;

  typedef enum logic [2:0] {
    F_YEAR = 3'd0, F_MON = 3'd1, F_DOM = 3'd2, F_DOW = 3'd3,
    F_HOUR = 3'd4, F_MIN = 3'd5, F_SEC = 3'd6
  } field_e;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam cal_time_t TIME_RESET = '{year: 7'd0, mon: 4'd1, dom: 5'd1,
                                       dow: 3'd0, hour: 5'd0, min: 6'd0, sec: 6'd0};

  function automatic logic cal_is_leap(input logic [6:0] y);
    return (y != 7'd0) && (y[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] cal_month_days(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] cal_get(input cal_time_t t, input logic [2:0] idx);
    case (idx)
      3'd0:    return t.year;
      3'd1:    return {3'd0, t.mon};
      3'd2:    return {2'd0, t.dom};
      3'd3:    return {4'd0, t.dow};
      3'd4:    return {2'd0, t.hour};
      3'd5:    return {1'b0, t.min};
      3'd6:    return {1'b0, t.sec};
      default: return '0;
    endcase
  endfunction

  function automatic cal_time_t cal_put(input cal_time_t t, input logic [2:0] idx,
                                        input logic [FIELD_W-1:0] v);
    cal_time_t r;
    r = t;
    case (idx)
      3'd0:    r.year = v;
      3'd1:    r.mon  = v[3:0];
      3'd2:    r.dom  = v[4:0];
      3'd3:    r.dow  = v[2:0];
      3'd4:    r.hour = v[4:0];
      3'd5:    r.min  = v[5:0];
      3'd6:    r.sec  = v[5:0];
      default: r = t;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  cal_time_t cur,
  output cal_time_t nxt,
  output logic      day_carry
);
  localparam logic [6:0] YL = 7'(YEAR_LAST);

  logic c_sec, c_min, c_hour, c_dom, c_mon;
  logic [4:0] mdays;

  always_comb begin
    mdays   = cal_month_days(cur.mon, cal_is_leap(cur.year));
    c_sec   = (cur.sec  >= 6'd59);
    c_min   = c_sec  && (cur.min  >= 6'd59);
    c_hour  = c_min  && (cur.hour >= 5'd23);
    c_dom   = c_hour && (cur.dom  >= mdays);
    c_mon   = c_dom  && (cur.mon  >= 4'd12);

    nxt      = cur;
    nxt.sec  = c_sec  ? 6'd0 : cur.sec + 6'd1;
    if (c_sec)  nxt.min  = c_min  ? 6'd0 : cur.min + 6'd1;
    if (c_min)  nxt.hour = c_hour ? 5'd0 : cur.hour + 5'd1;
    if (c_hour) begin
      nxt.dom = c_dom ? 5'd1 : cur.dom + 5'd1;
      nxt.dow = (cur.dow >= 3'd6) ? 3'd0 : cur.dow + 3'd1;
    end
    if (c_dom)  nxt.mon  = c_mon ? 4'd1 : cur.mon + 4'd1;
    if (c_mon)  nxt.year = (cur.year >= YL) ? 7'd0 : cur.year + 7'd1;
    day_carry = c_hour;
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_pkg::*;
(
  input  cal_time_t         t,
  input  cal_time_t         alm,
  input  logic [NFIELD-1:0] cmp_en,
  output logic              match
);
  logic [NFIELD-1:0] fld_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign fld_ok[i] = !cmp_en[i] ||
                       (cal_get(t, 3'(i)) == cal_get(alm, 3'(i)));
  end

  assign match = &fld_ok;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  cal_time_t cur, nxt, alm;
  logic       ctl_stop;
  logic [7:0] alm_ctl;
  logic       status;
  logic       day_carry;
  logic       match;

  logic       wr_en, time_wr, alm_wr, ctl_wr, stat_wr, actl_wr;
  logic [2:0] fidx;
  logic       adv_fire, alarm_hit, status_clr;

  assign wr_en   = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
  assign fidx    = bus_addr[4:2];
  assign time_wr = wr_en && (bus_addr[7:5] == 3'b010) && (fidx != 3'd7);
  assign alm_wr  = wr_en && (bus_addr[7:5] == 3'b011) && (fidx != 3'd7);
  assign ctl_wr  = wr_en && (bus_addr == A_CTL);
  assign stat_wr = wr_en && (bus_addr == A_STAT);
  assign actl_wr = wr_en && (bus_addr == A_ACTL);

  cal_advance #(.YEAR_LAST(YEAR_LAST)) u_adv (
    .cur(cur), .nxt(nxt), .day_carry(day_carry)
  );

  cal_alarm_match u_match (
    .t(nxt), .alm(alm), .cmp_en(alm_ctl[7:1]), .match(match)
  );

  assign adv_fire   = tick_1hz && !ctl_stop && !time_wr;
  assign alarm_hit  = adv_fire && match && alm_ctl[0];
  assign status_clr = stat_wr && bus_wdata[STAT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= TIME_RESET;
      alm      <= '0;
      ctl_stop <= 1'b1;
      alm_ctl  <= '0;
      status   <= 1'b0;
    end else begin
      if (time_wr)       cur <= cal_put(cur, fidx, bus_wdata[FIELD_W-1:0]);
      else if (adv_fire) cur <= nxt;
      if (alm_wr)  alm      <= cal_put(alm, fidx, bus_wdata[FIELD_W-1:0]);
      if (ctl_wr)  ctl_stop <= bus_wdata[0];
      if (actl_wr) alm_ctl  <= bus_wdata[7:0];
      if (alarm_hit)       status <= 1'b1;
      else if (status_clr) status <= 1'b0;
    end
  end

  assign irq = status && alm_ctl[0];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:5] == 3'b010 && fidx != 3'd7 && bus_addr[1:0] == 2'b00)
      bus_rdata = DATA_W'(cal_get(cur, fidx));
    else if (bus_addr[7:5] == 3'b011 && fidx != 3'd7 && bus_addr[1:0] == 2'b00)
      bus_rdata = DATA_W'(cal_get(alm, fidx));
    else if (bus_addr == A_CTL)
      bus_rdata = DATA_W'(ctl_stop);
    else if (bus_addr == A_STAT)
      bus_rdata = DATA_W'(status) << STAT_BIT;
    else if (bus_addr == A_ACTL)
      bus_rdata = DATA_W'(alm_ctl);
  end
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      ctl_stop,
  input logic      time_wr,
  input logic      adv_fire,
  input logic      alarm_hit,
  input logic      status_clr,
  input logic      status,
  input logic      irq,
  input cal_time_t cur
);
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stop && !time_wr) |=> (cur == $past(cur)));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && cur.sec < 6'd59) |=> (cur.sec == $past(cur.sec) + 6'd1));

  assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> status);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !alarm_hit) |=> !status);

  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !status_clr) |=> status);
endmodule

bind cal_clock cal_clock_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_stop(ctl_stop), .time_wr(time_wr),
  .adv_fire(adv_fire), .alarm_hit(alarm_hit), .status_clr(status_clr),
  .status(status), .irq(irq), .cur(cur)
);

// File: tb/cal_clock_bench.sv
module cal_clock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cal_clock u_cal_clock (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [7:0] TB = 8'h40, AB = 8'h60;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick_1hz = with_tick;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_1hz = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = int'(bus_rdata);
    bus_sel = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1;
      @(negedge clk); tick_1hz = 0;
    end
  endtask

  task automatic set_time(input int y, mo, d, w, h, mi, s);
    wr(8'h20, 1);
    wr(TB + 0, y); wr(TB + 4, mo); wr(TB + 8, d); wr(TB + 12, w);
    wr(TB + 16, h); wr(TB + 20, mi); wr(TB + 24, s);
    wr(8'h20, 0);
  endtask

  task automatic expect_time(input string req, input int y, mo, d, w, h, mi, s);
    int v;
    rd(TB + 0, v);  check({req, " year"}, v, y);
    rd(TB + 4, v);  check({req, " month"}, v, mo);
    rd(TB + 8, v);  check({req, " dom"}, v, d);
    rd(TB + 12, v); check({req, " dow"}, v, w);
    rd(TB + 16, v); check({req, " hour"}, v, h);
    rd(TB + 20, v); check({req, " min"}, v, mi);
    rd(TB + 24, v); check({req, " sec"}, v, s);
  endtask

  task automatic t_reset();
    int v;
    expect_time("R1 reset", 0, 1, 1, 0, 0, 0, 0);
    rd(8'h20, v); check("R1 stop", v, 1);
    rd(8'h7C, v); check("R1 alarm ctl", v, 0);
    rd(8'h30, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_map();
    int v;
    wr(AB + 24, 33); wr(AB + 4, 11);
    rd(AB + 24, v); check("R2 alarm sec readback", v, 33);
    rd(AB + 4, v);  check("R2 alarm month readback", v, 11);
    set_time(7, 3, 9, 2, 10, 20, 30);
    expect_time("R2 layout", 7, 3, 9, 2, 10, 20, 30);
  endtask

  task automatic t_count();
    int v;
    set_time(7, 3, 9, 2, 10, 58, 57);
    tick(3);
    expect_time("R3 sec/min carry", 7, 3, 9, 2, 10, 59, 0);
    wr(8'h20, 1);
    tick(2);
    rd(TB + 24, v); check("R4 frozen sec", v, 0);
    wr(8'h20, 0);
    tick(1);
    rd(TB + 24, v); check("R4 resume sec", v, 1);
  endtask

  task automatic t_calendar();
    set_time(99, 12, 31, 6, 23, 59, 59);
    tick(1);
    expect_time("R6 R7 R5 full rollover", 0, 1, 1, 0, 0, 0, 0);
    set_time(4, 2, 28, 1, 23, 59, 59);
    tick(1);
    expect_time("R6 leap feb", 4, 2, 29, 2, 0, 0, 0);
    set_time(0, 2, 28, 3, 23, 59, 59);
    tick(1);
    expect_time("R6 year0 feb", 0, 3, 1, 4, 0, 0, 0);
    set_time(1, 2, 28, 3, 23, 59, 59);
    tick(1);
    expect_time("R5 common feb", 1, 3, 1, 4, 0, 0, 0);
    set_time(1, 4, 30, 5, 23, 59, 59);
    tick(1);
    expect_time("R5 april end", 1, 5, 1, 6, 0, 0, 0);
    set_time(1, 4, 29, 0, 23, 59, 59);
    tick(1);
    expect_time("R5 mid month", 1, 4, 30, 1, 0, 0, 0);
  endtask

  task automatic t_alarm();
    int v;
    wr(AB + 24, 10); wr(AB + 20, 5);
    set_time(5, 3, 7, 2, 12, 0, 8);
    wr(8'h7C, 32'hC1);
    tick(2);
    rd(8'h30, v); check("R8 min mismatch no hit", v, 0);
    set_time(5, 3, 7, 2, 12, 0, 9);
    wr(8'h7C, 32'h80);
    tick(1);
    rd(8'h30, v); check("R8 master off no hit", v, 0);
    set_time(5, 3, 7, 2, 12, 0, 9);
    wr(8'h7C, 32'h81);
    tick(1);
    rd(8'h30, v); check("R8 hit status", v, 16);
    check("R9 irq high", irq, 1);
    wr(8'h30, 32'hEF);
    rd(8'h30, v); check("R10 zero write ignored", v, 16);
    wr(8'h30, 32'h10);
    rd(8'h30, v); check("R10 clear", v, 0);
    check("R9 irq low after clear", irq, 0);
    set_time(5, 3, 7, 2, 12, 0, 9);
    tick(1);
    check("R9 irq again", irq, 1);
    wr(8'h7C, 0);
    check("R9 irq off by ctl", irq, 0);
    rd(8'h30, v); check("R9 status kept", v, 16);
    wr(8'h30, 32'h10);
  endtask

  task automatic t_collide();
    int v;
    set_time(5, 3, 7, 2, 12, 0, 9);
    wr(8'h7C, 32'h81);
    wr(8'h30, 32'h10, 1);
    rd(8'h30, v); check("R11 hit beats clear", v, 16);
    wr(8'h30, 32'h10);
    rd(TB + 24, v); check("R11 tick applied", v, 10);
    wr(TB + 24, 30, 1);
    rd(TB + 24, v); check("R11 write beats tick", v, 30);
    tick(1);
    rd(TB + 24, v); check("R11 next tick", v, 31);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_count();
    t_calendar();
    t_alarm();
    t_collide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule